// File: doc/BRIEF.md
# Subroutine Call and Return Stack Unit

This unit steers the program counter of a small 8-bit controller core through subroutine calls, returns and single-byte stack traffic. A request carries an operation code together with the current instruction address, an immediate value, the 16-bit Z pointer with its 6-bit extension, and a register byte. The unit then walks the stack one byte per clock in a byte-wide data memory that it holds internally. When the walk ends it pulses `done`. At that point it presents the next program counter, the popped byte for a pop, an interrupt-enable strobe for a return-from-interrupt, and the architectural cycle cost of the operation.

A mode input selects a 16-bit or a 22-bit program counter. In the wide mode, calls and returns move a third return-address byte and each cost one extra cycle. Every program counter the unit produces is masked to the program-memory size, which is set by a parameter. Instruction decode and arithmetic are handled elsewhere.

Top module: `callstk_unit`

## Requirements
- R1: PUSH (op 6) writes `reg_byte` at the address in the stack pointer and then lowers the pointer by one. It reports 2 cycles and sets `next_pc` to the masked `cur_pc`+1.
- R2: POP (op 7) raises the stack pointer by one and then returns the byte at the new address on `pop_data`. It reports 2 cycles.
- R3: A call pushes its return address least significant byte first. The bytes land at SP, SP-1 and, in wide mode, SP-2, and the pointer drops by 2 (narrow) or 3 (wide).
- R4: RET (op 4) pops the return address most significant byte first. In narrow mode it pops two bytes and bits 21:16 are zero. In wide mode it pops three bytes, and the low 6 bits of the first byte form bits 21:16.
- R5: RET and RETI report 4 cycles in narrow mode and 5 cycles in wide mode.
- R6: RETI (op 5) behaves as RET and also pulses `ie_set` together with `done`. No other operation asserts `ie_set`.
- R7: A relative call (op 0) targets `cur_pc`+1 plus the sign-extended value of `imm_addr[11:0]`. Its return address is `cur_pc`+1.
- R8: An absolute call (op 1) targets `imm_addr`. Its return address is `cur_pc`+2.
- R9: An indirect call (op 2) targets `{6'b0, z_ptr}`. The extended indirect call (op 3) targets `{z_ext, z_ptr}`. Both return to `cur_pc`+1.
- R10: Every target, return address and popped program counter is masked to the low `PMEM_AW` bits.
- R11: Calls report 3 cycles for op 0 and op 2, and 4 cycles for op 1 and op 3, plus one in wide mode.
- R12: After reset the stack pointer equals `SP_RESET`, and `busy`, `done` and `ie_set` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request strobe, taken when `busy` is low |
| op_code | input | 3 | 0 rel call, 1 abs call, 2 ind call, 3 ext ind call, 4 RET, 5 RETI, 6 PUSH, 7 POP |
| wide_pc | input | 1 | 1 selects the 22-bit program counter |
| cur_pc | input | 22 | Word address of the current instruction |
| imm_addr | input | 22 | Absolute target, or 12-bit offset in bits 11:0 |
| z_ptr | input | 16 | Z pointer value |
| z_ext | input | 6 | Bits 21:16 for the extended indirect call |
| reg_byte | input | 8 | Byte to push |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | 22 | Next program counter, valid with `done` |
| pop_data | output | 8 | Byte from the latest POP |
| ie_set | output | 1 | Interrupt-enable set strobe |
| op_cycles | output | 3 | Cycle cost of the completed operation |
| stk_ptr | output | 16 | Stack pointer |

## Verification
The assertions take for granted that a request is raised only while `busy` is low, and that a return pops bytes which an earlier call or push placed on the stack. The scoreboard driver waits for `busy` to fall before it raises `op_valid` for one cycle. It keeps its own byte-stack model, so every return it issues reads back bytes it has already written. With the mask set to 18 bits, the stimulus includes targets above the mask, negative relative offsets and hand-pushed return frames in both modes.

// File: rtl/callstk_pkg.sv
package callstk_pkg;

   localparam int PC_W = 22;

   typedef enum logic [2:0] {
      OP_RCALL  = 3'd0,
      OP_CALL   = 3'd1,
      OP_ICALL  = 3'd2,
      OP_EICALL = 3'd3,
      OP_RET    = 3'd4,
      OP_RETI   = 3'd5,
      OP_PUSH   = 3'd6,
      OP_POP    = 3'd7
   } stk_op_e;

   localparam logic [2:0] CYC_SHORT_CALL = 3'd3;
   localparam logic [2:0] CYC_LONG_CALL  = 3'd4;
   localparam logic [2:0] CYC_RETURN     = 3'd4;
   localparam logic [2:0] CYC_BYTE       = 3'd2;

   function automatic logic is_write_op(input stk_op_e op);
      return (op != OP_RET) && (op != OP_RETI) && (op != OP_POP);
   endfunction

   function automatic logic is_return_op(input stk_op_e op);
      return (op == OP_RET) || (op == OP_RETI);
   endfunction

endpackage

// File: rtl/callstk_ram.sv
module callstk_ram #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem_q[addr] <= wdata;
      end
   end

   assign rdata = mem_q[addr];

endmodule

// File: rtl/callstk_target.sv
module callstk_target
   import callstk_pkg::*;
#(
   parameter int PMEM_AW = 16,
   parameter bit WIDE_EN = 1'b1
) (
   input  stk_op_e         op,
   input  logic            wide_mode,
   input  logic [PC_W-1:0] cur_pc,
   input  logic [PC_W-1:0] imm,
   input  logic [15:0]     zptr,
   input  logic [5:0]      zext,
   output logic [PC_W-1:0] target,
   output logic [PC_W-1:0] ret_addr,
   output logic [1:0]      nbytes,
   output logic [2:0]      cycles
);
   localparam logic [PC_W-1:0] PC_MASK = PC_W'((64'd1 << PMEM_AW) - 64'd1);

   logic            wide_eff;
   logic [PC_W-1:0] pc_inc1;
   logic [PC_W-1:0] pc_inc2;
   logic [PC_W-1:0] rel_tgt;
   logic [PC_W-1:0] raw_tgt;
   logic [PC_W-1:0] raw_ret;
   logic [2:0]      base_cyc;
   logic            mode_extra;

   generate
      if (WIDE_EN) begin : g_wide
         assign wide_eff = wide_mode;
      end else begin : g_narrow
         logic unused_wide;
         assign unused_wide = wide_mode;
         assign wide_eff    = 1'b0;
      end
   endgenerate

   assign pc_inc1 = cur_pc + PC_W'(1);
   assign pc_inc2 = cur_pc + PC_W'(2);
   assign rel_tgt = pc_inc1 + {{(PC_W-12){imm[11]}}, imm[11:0]};

   always_comb begin
      raw_tgt    = pc_inc1;
      raw_ret    = pc_inc1;
      base_cyc   = CYC_BYTE;
      mode_extra = 1'b0;
      nbytes     = 2'd1;
      unique case (op)
         OP_RCALL: begin
            raw_tgt    = rel_tgt;
            base_cyc   = CYC_SHORT_CALL;
            mode_extra = 1'b1;
         end
         OP_CALL: begin
            raw_tgt    = imm;
            raw_ret    = pc_inc2;
            base_cyc   = CYC_LONG_CALL;
            mode_extra = 1'b1;
         end
         OP_ICALL: begin
            raw_tgt    = {6'd0, zptr};
            base_cyc   = CYC_SHORT_CALL;
            mode_extra = 1'b1;
         end
         OP_EICALL: begin
            raw_tgt    = {zext, zptr};
            base_cyc   = CYC_LONG_CALL;
            mode_extra = 1'b1;
         end
         OP_RET, OP_RETI: begin
            base_cyc   = CYC_RETURN;
            mode_extra = 1'b1;
         end
         default: begin
            base_cyc = CYC_BYTE;
         end
      endcase
      if (mode_extra) begin
         nbytes = wide_eff ? 2'd3 : 2'd2;
      end
   end

   assign target   = raw_tgt & PC_MASK;
   assign ret_addr = raw_ret & PC_MASK;
   assign cycles   = base_cyc + {2'd0, mode_extra & wide_eff};

endmodule

// File: rtl/callstk_ctrl.sv
module callstk_ctrl
   import callstk_pkg::*;
#(
   parameter int          PMEM_AW  = 16,
   parameter int          MEM_AW   = 8,
   parameter int          SP_W     = 16,
   parameter logic [15:0] SP_RESET = 16'h00FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  stk_op_e           op,
   input  logic [PC_W-1:0]   target,
   input  logic [PC_W-1:0]   ret_addr,
   input  logic [1:0]        nbytes,
   input  logic [2:0]        cycles,
   input  logic [7:0]        reg_byte,
   input  logic [7:0]        rd_data,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              busy,
   output logic              done,
   output logic [PC_W-1:0]   next_pc,
   output logic [7:0]        pop_data,
   output logic              ie_set,
   output logic [2:0]        op_cycles,
   output logic [SP_W-1:0]   sp
);
   localparam logic [23:0] ACC_MASK = 24'((64'd1 << PMEM_AW) - 64'd1);

   stk_op_e         kind_q;
   logic [1:0]      cnt_q;
   logic [23:0]     shift_q;
   logic [23:0]     acc_q;
   logic [23:0]     acc_nxt;
   logic [PC_W-1:0] target_q;
   logic [2:0]      cyc_q;
   logic [SP_W-1:0] sp_inc;
   logic            wr_kind;
   logic            rd_kind;

   assign wr_kind   = busy && is_write_op(kind_q);
   assign rd_kind   = busy && !is_write_op(kind_q);
   assign sp_inc    = sp + SP_W'(1);
   assign mem_we    = wr_kind;
   assign mem_addr  = wr_kind ? MEM_AW'(sp) : MEM_AW'(sp_inc);
   assign mem_wdata = shift_q[7:0];
   assign acc_nxt   = {acc_q[15:0], rd_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         ie_set    <= 1'b0;
         kind_q    <= OP_RCALL;
         cnt_q     <= 2'd0;
         shift_q   <= '0;
         acc_q     <= '0;
         target_q  <= '0;
         cyc_q     <= '0;
         next_pc   <= '0;
         pop_data  <= '0;
         op_cycles <= '0;
         sp        <= SP_W'(SP_RESET);
      end else begin
         done   <= 1'b0;
         ie_set <= 1'b0;
         if (!busy && op_valid) begin
            busy     <= 1'b1;
            kind_q   <= op;
            cnt_q    <= nbytes;
            shift_q  <= (op == OP_PUSH) ? {16'd0, reg_byte} : {2'd0, ret_addr};
            acc_q    <= '0;
            target_q <= target;
            cyc_q    <= cycles;
         end else if (busy) begin
            if (wr_kind) begin
               sp      <= sp - SP_W'(1);
               shift_q <= shift_q >> 8;
            end else begin
               sp    <= sp_inc;
               acc_q <= acc_nxt;
            end
            cnt_q <= cnt_q - 2'd1;
            if (cnt_q == 2'd1) begin
               busy      <= 1'b0;
               done      <= 1'b1;
               op_cycles <= cyc_q;
               ie_set    <= (kind_q == OP_RETI);
               if (is_return_op(kind_q)) begin
                  next_pc <= PC_W'(acc_nxt & ACC_MASK);
               end else begin
                  next_pc <= target_q;
               end
               if (kind_q == OP_POP) begin
                  pop_data <= rd_data;
               end
            end
         end
      end
   end

   // R1 (push) and R3 (call frames): each written byte lowers SP by one
   p_wr_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_kind |=> (sp == $past(sp) - SP_W'(1)));

   // R2 (pop) and R4 (return frames): each read raises SP first
   p_rd_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_kind |=> (sp == $past(sp) + SP_W'(1)));

   p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: rtl/callstk_unit.sv
module callstk_unit
   import callstk_pkg::*;
#(
   parameter int          PMEM_AW  = 16,
   parameter int          MEM_AW   = 8,
   parameter int          SP_W     = 16,
   parameter logic [15:0] SP_RESET = 16'h00FF,
   parameter bit          WIDE_EN  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        op_valid,
   input  logic [2:0]  op_code,
   input  logic        wide_pc,
   input  logic [21:0] cur_pc,
   input  logic [21:0] imm_addr,
   input  logic [15:0] z_ptr,
   input  logic [5:0]  z_ext,
   input  logic [7:0]  reg_byte,
   output logic        busy,
   output logic        done,
   output logic [21:0] next_pc,
   output logic [7:0]  pop_data,
   output logic        ie_set,
   output logic [2:0]  op_cycles,
   output logic [15:0] stk_ptr
);
   localparam logic [PC_W-1:0] PC_MASK = PC_W'((64'd1 << PMEM_AW) - 64'd1);

   generate
      if (PMEM_AW < 8 || PMEM_AW > PC_W) begin : g_bad_pmem
         $error("PMEM_AW must lie between 8 and 22");
      end
      if (MEM_AW < 4 || MEM_AW > 12) begin : g_bad_mem
         $error("MEM_AW must lie between 4 and 12");
      end
      if (SP_W != 16) begin : g_bad_sp
         $error("SP_W must be 16");
      end
   endgenerate

   stk_op_e           op_e;
   logic [PC_W-1:0]   target;
   logic [PC_W-1:0]   ret_addr;
   logic [1:0]        nbytes;
   logic [2:0]        cycles;
   logic              mem_we;
   logic [MEM_AW-1:0] mem_addr;
   logic [7:0]        mem_wdata;
   logic [7:0]        mem_rdata;

   assign op_e = stk_op_e'(op_code);

   callstk_target #(.PMEM_AW(PMEM_AW), .WIDE_EN(WIDE_EN)) target_i (
      .op(op_e), .wide_mode(wide_pc), .cur_pc(cur_pc), .imm(imm_addr),
      .zptr(z_ptr), .zext(z_ext), .target(target), .ret_addr(ret_addr),
      .nbytes(nbytes), .cycles(cycles)
   );

   callstk_ctrl #(
      .PMEM_AW(PMEM_AW), .MEM_AW(MEM_AW), .SP_W(SP_W), .SP_RESET(SP_RESET)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op_e),
      .target(target), .ret_addr(ret_addr), .nbytes(nbytes), .cycles(cycles),
      .reg_byte(reg_byte), .rd_data(mem_rdata), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
      .next_pc(next_pc), .pop_data(pop_data), .ie_set(ie_set),
      .op_cycles(op_cycles), .sp(stk_ptr)
   );

   callstk_ram #(.AW(MEM_AW)) ram_i (
      .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
      .rdata(mem_rdata)
   );

   p_pc_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((next_pc & ~PC_MASK) == '0));

   p_ie_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ie_set |-> done);

   p_reti_cycles_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ie_set |-> (op_cycles == 3'd4 || op_cycles == 3'd5));

   p_cycle_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (op_cycles >= 3'd2 && op_cycles <= 3'd5));

endmodule

// File: tb/callstk_unit_tb.sv
module callstk_unit_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam int          PM_AW      = 18;
   localparam logic [15:0] SP_RST     = 16'h00FF;
   localparam logic [21:0] MASK       = 22'h03FFFF;

   typedef struct {
      logic [21:0] pc;
      logic [7:0]  pd;
      bit          chk_pd;
      logic        ie;
      logic [2:0]  cyc;
      logic [15:0] sp;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic        wide_pc = 1'b0;
   logic [21:0] cur_pc = '0;
   logic [21:0] imm_addr = '0;
   logic [15:0] z_ptr = '0;
   logic [5:0]  z_ext = '0;
   logic [7:0]  reg_byte = '0;
   logic        busy, done, ie_set;
   logic [21:0] next_pc;
   logic [7:0]  pop_data;
   logic [2:0]  op_cycles;
   logic [15:0] stk_ptr;

   int   n_checks = 0;
   int   n_fails  = 0;
   bit   finished = 0;
   exp_t sb_q[$];
   logic [7:0]  mdl [256];
   logic [15:0] msp = SP_RST;

   always #(CLK_PERIOD/2) clk = ~clk;

   callstk_unit #(.PMEM_AW(PM_AW), .MEM_AW(8), .SP_RESET(SP_RST)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .wide_pc(wide_pc), .cur_pc(cur_pc), .imm_addr(imm_addr), .z_ptr(z_ptr),
      .z_ext(z_ext), .reg_byte(reg_byte), .busy(busy), .done(done),
      .next_pc(next_pc), .pop_data(pop_data), .ie_set(ie_set),
      .op_cycles(op_cycles), .stk_ptr(stk_ptr)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic mpush(input logic [7:0] b);
      mdl[msp[7:0]] = b;
      msp = msp - 16'd1;
   endtask

   function automatic logic [7:0] mpop();
      msp = msp + 16'd1;
      return mdl[msp[7:0]];
   endfunction

   task automatic run_op(input logic [2:0] op, input logic [21:0] cur,
                         input logic [21:0] imm, input logic [15:0] z,
                         input logic [5:0] ze, input logic [7:0] rb,
                         input bit wide, input string tag);
      exp_t e;
      logic [21:0] ret;
      logic [7:0]  b1, b2, b3;
      e.pd = '0; e.chk_pd = 0; e.ie = 1'b0; e.tag = tag;
      ret = (op == 3'd1) ? ((cur + 22'd2) & MASK) : ((cur + 22'd1) & MASK);
      e.pc = (cur + 22'd1) & MASK;
      case (op)
         3'd0: begin e.pc = ((cur + 22'd1) + {{10{imm[11]}}, imm[11:0]}) & MASK; e.cyc = 3'd3; end
         3'd1: begin e.pc = imm & MASK;          e.cyc = 3'd4; end
         3'd2: begin e.pc = {6'd0, z} & MASK;    e.cyc = 3'd3; end
         3'd3: begin e.pc = {ze, z} & MASK;      e.cyc = 3'd4; end
         3'd4, 3'd5: begin
            e.cyc = 3'd4;
            e.ie  = (op == 3'd5);
            b1 = mpop(); b2 = mpop();
            if (wide) begin
               b3 = mpop();
               e.pc = {b1[5:0], b2, b3} & MASK;
            end else begin
               e.pc = {6'd0, b1, b2} & MASK;
            end
         end
         3'd6: begin mpush(rb); e.cyc = 3'd2; end
         default: begin e.pd = mpop(); e.chk_pd = 1; e.cyc = 3'd2; end
      endcase
      if (op <= 3'd3) begin
         mpush(ret[7:0]);
         mpush(ret[15:8]);
         if (wide) mpush({2'd0, ret[21:16]});
      end
      if (op <= 3'd5 && wide) e.cyc = e.cyc + 3'd1;
      e.sp = msp;
      @(negedge clk);
      while (busy) @(negedge clk);
      op_code = op; cur_pc = cur; imm_addr = imm; z_ptr = z; z_ext = ze;
      reg_byte = rb; wide_pc = wide; op_valid = 1'b1;
      sb_q.push_back(e);
      @(negedge clk);
      op_valid = 1'b0;
      while (!done) @(negedge clk);
   endtask

   // Monitor: pops expectations as results appear
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb_q.size() == 0) begin
            check("R12", "unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "next_pc", 32'(next_pc), 32'(e.pc));
            check(e.tag, "op_cycles", 32'(op_cycles), 32'(e.cyc));
            check(e.tag, "ie_set", 32'(ie_set), 32'(e.ie));
            check(e.tag, "stk_ptr", 32'(stk_ptr), 32'(e.sp));
            if (e.chk_pd) check(e.tag, "pop_data", 32'(pop_data), 32'(e.pd));
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12", "reset sp", 32'(stk_ptr), 32'(SP_RST));
      check("R12", "reset done", 32'(done), 32'd0);
      check("R12", "reset ie_set", 32'(ie_set), 32'd0);
      check("R12", "reset busy", 32'(busy), 32'd0);
      // R1 / R2: byte push and pop
      run_op(3'd6, 22'h000010, '0, '0, '0, 8'hA5, 0, "R1");
      run_op(3'd6, 22'h000011, '0, '0, '0, 8'h3C, 0, "R1");
      run_op(3'd7, 22'h000012, '0, '0, '0, 8'h00, 0, "R2");
      run_op(3'd7, 22'h000013, '0, '0, '0, 8'h00, 0, "R2");
      // R7 R11 relative call, R4 R5 return
      run_op(3'd0, 22'h000100, 22'h000005, '0, '0, '0, 0, "R7_R11");
      run_op(3'd4, 22'h000106, '0, '0, '0, '0, 0, "R4_R5");
      run_op(3'd0, 22'h000100, 22'h000FFE, '0, '0, '0, 0, "R7");
      run_op(3'd4, 22'h0000FF, '0, '0, '0, '0, 0, "R4");
      // R8 R3 wide absolute call, R6 return from interrupt
      run_op(3'd1, 22'h020010, 22'h031234, '0, '0, '0, 1, "R8_R3");
      run_op(3'd5, 22'h031234, '0, '0, '0, '0, 1, "R6_R5");
      // R9 indirect forms, R10 masking
      run_op(3'd2, 22'h000040, '0, 16'hBEEF, '0, '0, 0, "R9");
      run_op(3'd4, 22'h00BEEF, '0, '0, '0, '0, 0, "R4");
      run_op(3'd3, 22'h000050, '0, 16'h1234, 6'h3F, '0, 1, "R9_R10");
      run_op(3'd4, 22'h031234, '0, '0, '0, '0, 1, "R4_R5");
      run_op(3'd1, 22'h000060, 22'h3FFFFF, '0, '0, '0, 0, "R10_R11");
      run_op(3'd5, 22'h03FFFF, '0, '0, '0, '0, 0, "R6");
      // R4 byte order on hand-built frames
      run_op(3'd6, 22'h000070, '0, '0, '0, 8'h12, 0, "R1");
      run_op(3'd6, 22'h000071, '0, '0, '0, 8'h34, 0, "R1");
      run_op(3'd4, 22'h000072, '0, '0, '0, '0, 0, "R4");
      run_op(3'd6, 22'h000080, '0, '0, '0, 8'h01, 0, "R1");
      run_op(3'd6, 22'h000081, '0, '0, '0, 8'h02, 0, "R1");
      run_op(3'd6, 22'h000082, '0, '0, '0, 8'h03, 0, "R1");
      run_op(3'd4, 22'h000083, '0, '0, '0, '0, 1, "R4");
      repeat (3) @(negedge clk);
      check("R12", "scoreboard drained", 32'(sb_q.size()), 32'd0);
      finish_run();
   end

endmodule